// File: doc/BRIEF.md
# Access-Field Pulse-Position Encoder

This block turns a 12-bit access field into a train of carrier bursts whose spacing carries the data. A start strobe latches the field and at once launches a reference burst. Six symbols follow. Each one carries a bit pair. The pair sets how long the encoder waits after the start of the previous burst before it launches the next one. Every burst is four periods of a square wave at the carrier frequency, taken straight from the clock.

The access field is made of an 8-bit identifier in bits 11:4 and a 4-bit control nibble in bits 3:0. It goes out most significant pair first. The symbol spacing is fixed, so the field always takes the same form whatever data rate the rest of the link uses. Every timing value is a parameter counted in clock ticks. A single-cycle completion flag marks the end of the last burst. A filter stage after this block shapes the square-wave drive into the line pulse.

Top module: `acc_ppm_encoder`

## Requirements
- R1: While reset is held and after it is released, `tx_drive` and `field_done` are 0, and no burst is produced until a start strobe is accepted.
- R2: A `start` sampled high while the encoder is idle latches `field_word` and begins the reference burst. `tx_drive` is 1 in the cycle right after that clock edge.
- R3: Every burst lasts 8*HALF_TICKS cycles. It has four square-wave periods, and each period is HALF_TICKS cycles high followed by HALF_TICKS cycles low, beginning with the high half.
- R4: The six symbols carry `field_word` bit pairs in the order [11:10], [9:8], [7:6], [5:4], [3:2], [1:0]. The identifier bits therefore go before the control bits.
- R5: The distance in cycles from the start of one burst to the start of the next is SYM_TICKS plus the offset of the pair carried. The offset is 0 for pair 00, OFF1 for 01, OFF2 for 10 and OFF3 for 11.
- R6: A field consists of exactly seven bursts: the reference and one for each of the six symbols. That is 28 rising edges of `tx_drive`.
- R7: `field_done` is 1 for exactly one cycle, in the first cycle after the last tick of the seventh burst. `tx_drive` is 0 in that cycle.
- R8: A `start` strobe that arrives while a field is in progress is ignored. The waveform under way and its completion time do not change.
- R9: `tx_drive` is 0 in every cycle that lies outside a burst, including the gaps between bursts.
- R10: A `start` sampled in the cycle where `field_done` is 1 is accepted, so fields can follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of every timing parameter |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a field; taken only when idle |
| field_word | input | 12 | Access field: identifier in 11:4, control in 3:0 |
| tx_drive | output | 1 | Square-wave burst drive to the line filter |
| field_done | output | 1 | One-cycle pulse after the final burst |

## Verification
The encoder is run with an all-zero field, which gives the tightest spacing, and with an all-ones field, which gives the widest. Two mixed fields follow in which every pair value appears at a different symbol position, so a swapped offset or a reversed pair order changes the waveform. Every cycle of every field is compared with a waveform built in the bench from the spacing rule. A strobe injected in the middle of a field tells a correctly ignored start apart from one that restarts the field. A strobe given in the completion cycle shows whether fields can run back to back.

// File: rtl/acc_ppm_pkg.sv
// Shared constants and types for the access-field pulse-position encoder.
// Assumes a 12-bit field sent as two-bit symbols.
package acc_ppm_pkg;
    localparam int FIELD_BITS   = 12;
    localparam int SYMBOLS      = FIELD_BITS / 2;
    localparam int BURST_PERIODS = 4;
    localparam int SYM_IDX_W    = $clog2(SYMBOLS + 1);

    typedef logic [1:0] pair_t;
endpackage

// File: rtl/acc_burst_gen.sv
// Burst generator: on a fire strobe it produces PERIODS square-wave periods,
// each HALF_TICKS cycles high and then HALF_TICKS cycles low.
// Assumes a fire strobe that arrives during a burst restarts that burst.
module acc_burst_gen #(
    parameter int HALF_TICKS = 4,
    parameter int PERIODS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic drive,
    output logic active,
    output logic last_tick
);
    localparam int HC_W   = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam int HALVES = 2 * PERIODS;
    localparam int PH_W   = $clog2(HALVES);

    logic [HC_W-1:0] half_cnt;
    logic [PH_W-1:0] phase;
    logic            half_end;

    assign half_end  = (half_cnt == HC_W'(HALF_TICKS - 1));
    assign last_tick = active && half_end && (phase == PH_W'(HALVES - 1));
    assign drive     = active && !phase[0];

    // Step through the half periods of the burst; fire restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            half_cnt <= '0;
            phase    <= '0;
        end else if (fire) begin
            active   <= 1'b1;
            half_cnt <= '0;
            phase    <= '0;
        end else if (active) begin
            if (half_end) begin
                half_cnt <= '0;
                if (phase == PH_W'(HALVES - 1)) begin
                    active <= 1'b0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acc_gap_timer.sv
// Gap timer: once loaded with N-1 it raises expire on the N-th clock edge
// after the load.
// Assumes a load takes priority over an expiry on the same edge.
module acc_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic         running;

    assign expire = running && (cnt == '0);

    // Count down to zero from the loaded value, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/acc_pair_shifter.sv
// Pair shifter: holds the field and presents its two leading bit pairs,
// then shifts left by one pair for each symbol sent.
// Assumes BITS is even and at least 4.
module acc_pair_shifter
    import acc_ppm_pkg::*;
#(
    parameter int BITS = FIELD_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] word,
    input  logic            shift,
    output pair_t           head,
    output pair_t           second
);
    logic [BITS-1:0] shreg;

    assign head   = shreg[BITS-1 -: 2];
    assign second = shreg[BITS-3 -: 2];

    // Load the field, or move the next pair into the head position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= word;
        end else if (shift) begin
            shreg <= {shreg[BITS-3:0], 2'b00};
        end
    end
endmodule

// File: rtl/acc_ppm_encoder.sv
// Access-field pulse-position encoder top level.
// A start strobe accepted while idle fires a reference burst. Each of the
// six pairs then fires a burst SYM_TICKS + offset(pair) cycles after the
// previous burst began. Assumes SYM_TICKS >= 8*HALF_TICKS, so a burst has
// finished before the next one fires, and OFF1 < OFF2 < OFF3.
module acc_ppm_encoder
    import acc_ppm_pkg::*;
#(
    parameter int HALF_TICKS = 4,
    parameter int SYM_TICKS  = 40,
    parameter int OFF1       = 8,
    parameter int OFF2       = 16,
    parameter int OFF3       = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FIELD_BITS-1:0] field_word,
    output logic                  tx_drive,
    output logic                  field_done
);
    localparam int TW = $clog2(SYM_TICKS + OFF3 + 1);

    logic                 busy;
    logic [SYM_IDX_W-1:0] sym_idx;
    logic                 go;
    logic                 gap_expire;
    logic                 fire;
    logic                 final_sym;
    logic                 timer_load;
    pair_t                head_pair;
    pair_t                next_pair;
    pair_t                load_pair;
    logic [TW-1:0]        gap_val;
    logic                 burst_active;
    logic                 burst_last;
    logic                 done_q;

    // Gap, minus one, that follows a burst carrying pair p.
    function automatic logic [TW-1:0] gap_minus_one(input pair_t p);
        int off;
        case (p)
            2'b00:   off = 0;
            2'b01:   off = OFF1;
            2'b10:   off = OFF2;
            default: off = OFF3;
        endcase
        return TW'(SYM_TICKS + off - 1);
    endfunction

    assign go         = start && !busy;
    assign fire       = go || gap_expire;
    assign final_sym  = gap_expire && (sym_idx == SYM_IDX_W'(SYMBOLS - 1));
    assign timer_load = go || (gap_expire && !final_sym);
    assign load_pair  = go ? field_word[FIELD_BITS-1 -: 2] : next_pair;
    assign gap_val    = gap_minus_one(load_pair);
    assign field_done = done_q;

    acc_pair_shifter #(.BITS(FIELD_BITS)) u_pairs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go),
        .word   (field_word),
        .shift  (gap_expire),
        .head   (head_pair),
        .second (next_pair)
    );

    acc_gap_timer #(.W(TW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (gap_val),
        .expire   (gap_expire)
    );

    acc_burst_gen #(.HALF_TICKS(HALF_TICKS), .PERIODS(BURST_PERIODS)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .drive     (tx_drive),
        .active    (burst_active),
        .last_tick (burst_last)
    );

    // Track which symbol is in flight and whether a field is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sym_idx <= '0;
        end else if (go) begin
            busy    <= 1'b1;
            sym_idx <= '0;
        end else begin
            if (gap_expire) begin
                sym_idx <= sym_idx + 1'b1;
            end
            if (burst_last && sym_idx == SYM_IDX_W'(SYMBOLS)) begin
                busy <= 1'b0;
            end
        end
    end

    // Raise the completion flag for one cycle after the last burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= busy && burst_last && (sym_idx == SYM_IDX_W'(SYMBOLS));
        end
    end

    logic unused_head;
    assign unused_head = ^head_pair;
endmodule

// File: rtl/acc_ppm_checker.sv
// Property checker for the access-field encoder, bound into every instance.
// Assumes it sees the top's ports together with its busy, symbol index and
// burst-active state.
module acc_ppm_checker #(
    parameter int HALF_TICKS = 4,
    parameter int SYM_IDX_W  = 3,
    parameter int SYMBOLS    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 tx_drive,
    input logic                 field_done,
    input logic                 busy,
    input logic                 burst_active,
    input logic [SYM_IDX_W-1:0] sym_idx
);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |=> !field_done);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |-> !tx_drive);

    p_done_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |-> (sym_idx == SYM_IDX_W'(SYMBOLS)));

    p_ref_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> tx_drive);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (sym_idx >= $past(sym_idx)));

    p_gap_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> !tx_drive);

    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !burst_active);

    generate
        if (HALF_TICKS > 1) begin : g_wide_half
            p_high_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(tx_drive) |=> tx_drive);
        end
    endgenerate
endmodule

bind acc_ppm_encoder acc_ppm_checker #(
    .HALF_TICKS (HALF_TICKS),
    .SYM_IDX_W  (acc_ppm_pkg::SYM_IDX_W),
    .SYMBOLS    (acc_ppm_pkg::SYMBOLS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tx_drive     (tx_drive),
    .field_done   (field_done),
    .busy         (busy),
    .burst_active (burst_active),
    .sym_idx      (sym_idx)
);

// File: tb/tb_acc_ppm_encoder.sv
// Directed bench: each task runs one scenario and checks every cycle against
// a waveform computed from the spacing and burst-shape rules.
module tb_acc_ppm_encoder;
    localparam int H    = 4;
    localparam int SYM  = 40;
    localparam int O1   = 8;
    localparam int O2   = 16;
    localparam int O3   = 24;
    localparam int BLEN = 8 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] field_word = '0;
    logic        tx_drive;
    logic        field_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    acc_ppm_encoder #(
        .HALF_TICKS(H), .SYM_TICKS(SYM), .OFF1(O1), .OFF2(O2), .OFF3(O3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .field_word(field_word),
        .tx_drive(tx_drive), .field_done(field_done)
    );

    function automatic int offset_of(input logic [1:0] p);
        case (p)
            2'b00:   return 0;
            2'b01:   return O1;
            2'b10:   return O2;
            default: return O3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // R1: outputs quiet through reset and for a while after it.
    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            check(tx_drive == 1'b0 && field_done == 1'b0, "R1", "drive|done in reset",
                  {tx_drive, field_done}, 0);
        end
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check(tx_drive == 1'b0 && field_done == 1'b0, "R1", "drive|done after reset",
                  {tx_drive, field_done}, 0);
        end
    endtask

    // Run one field from the current negedge. poke_t >= 0 injects a second
    // start (R8) with poke_word at that sample. Returns in the done cycle.
    task automatic run_field(input logic [11:0] w, input string tag,
                             input int poke_t, input logic [11:0] poke_word);
        int fire_at[7];
        int tend;
        int rises;
        bit prev;
        fire_at[0] = 0;
        for (int k = 1; k <= 6; k++) begin
            fire_at[k] = fire_at[k-1] + SYM + offset_of(w[13 - 2*k -: 2]); // R4 order
        end
        tend  = fire_at[6] + BLEN;
        rises = 0;
        prev  = 1'b0;
        start = 1'b1;
        field_word = w;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= tend; t++) begin
            bit exp_d;
            int bk;
            exp_d = 1'b0;
            bk = -1;
            for (int k = 0; k <= 6; k++) begin
                if (t >= fire_at[k] && t < fire_at[k] + BLEN) begin
                    bk = k;
                    exp_d = (((t - fire_at[k]) / H) % 2) == 0;
                end
            end
            if (bk == 0)
                check(tx_drive == exp_d, "R2/R3", {tag, " reference burst"}, tx_drive, exp_d);
            else if (bk > 0)
                check(tx_drive == exp_d, "R3/R4/R5", {tag, " symbol burst"}, tx_drive, exp_d);
            else
                check(tx_drive == exp_d, "R9", {tag, " gap drive"}, tx_drive, exp_d);
            check(field_done == (t == tend), "R7", {tag, " done"}, field_done, t == tend);
            if (tx_drive && !prev) rises++;
            prev = tx_drive;
            if (t == poke_t) begin
                start = 1'b1;
                field_word = poke_word;
            end else begin
                start = 1'b0;
            end
            if (t != tend) @(negedge clk);
        end
        check(rises == 28, "R6", {tag, " rising edges"}, rises, 28);
    endtask

    // R9/R7: quiet after a field with no new start.
    task automatic t_quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tx_drive == 1'b0 && field_done == 1'b0, "R9", "idle after done",
                  {tx_drive, field_done}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_field(12'h000, "zeros", -1, '0);      // R5 tightest spacing
        t_quiet(5);
        run_field(12'hFFF, "ones", -1, '0);       // R5 widest spacing
        t_quiet(5);
        run_field(12'h1B4, "mixed_a", -1, '0);    // R4 pairs 00 01 10 11 01 00
        t_quiet(3);
        run_field(12'hE4D, "mixed_b", 100, 12'h000); // R8 start mid-field ignored
        // R10: next start given in the done cycle, no idle gap
        run_field(12'h9C6, "chain_1", -1, '0);
        run_field(12'h36C, "chain_2", -1, '0);
        t_quiet(5);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule